// File: doc/BRIEF.md
# Dual-Rail Precharged Ripple Adder Slice

This block adds two W-bit operands and a carry-in, with every logical bit inside the arithmetic carried as a pair of wires: a true rail and a false rail. Registered single-ended operands are turned into rail pairs at the register boundary. A phase signal forces both rails of every pair to zero during a precharge cycle. In the evaluation cycle that follows, exactly one rail of each pair goes high. The sum and carry network contains only non-inverting AND and OR terms. An all-zero input word therefore gives an all-zero output word, and the precharge moves through the network like a wave with no extra gating inside it.

Each operation takes two clocks. The first is a precharge clock, during which the operands are taken in. The second is an evaluation clock, at whose end the rail pairs of the result are captured and decoded back to single-ended bits. A monitor watches the result rail pairs on every clock. It reports any invalid codeword and counts the rails that rose and fell against the previous clock. For a correct design these counts do not depend on the data.

Top module: `dr_wave_adder`

## Requirements
- R1: While reset is high and in the first clock after it, eval_phase, sum_out, carry_out, code_err, rise_cnt and fall_cnt are all 0.
- R2: eval_phase is 0 in the first clock after reset and then inverts on every clock edge. A value of 1 marks an evaluation clock and 0 marks a precharge clock.
- R3: Operands a_in, b_in and c_in are sampled only at the clock edge that ends a precharge clock. Values applied during an evaluation clock have no effect on the result.
- R4: At the edge that ends an evaluation clock, {carry_out, sum_out} becomes a + b + cin for the operands sampled one edge earlier. This holds for every operand combination.
- R5: sum_out and carry_out keep their value through the whole following precharge clock and the next evaluation clock, until the next capture edge.
- R6: In a precharge clock both rails of every result pair are 0. Observed at the ports, rise_cnt is 0 and fall_cnt is W+1 in every precharge clock that follows an evaluation clock.
- R7: In an evaluation clock exactly one rail of each result pair is 1: the true rail for a bit value of 1 and the false rail for 0. Observed at the ports, rise_cnt is W+1 and fall_cnt is 0 whatever the operands.
- R8: code_err is a registered flag. It is 1 in the clock after any result pair read (1,1) or (0,0) during evaluation, or read anything other than (0,0) during precharge. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Operand A, single-ended |
| b_in | input | W | Operand B, single-ended |
| c_in | input | 1 | Carry-in, single-ended |
| eval_phase | output | 1 | 1 in an evaluation clock, 0 in a precharge clock |
| sum_out | output | W | Decoded sum bits from the capture register |
| carry_out | output | 1 | Decoded carry-out from the capture register |
| code_err | output | 1 | Invalid rail codeword seen in the previous clock |
| rise_cnt | output | CW | Result rails that rose since the previous clock |
| fall_cnt | output | CW | Result rails that fell since the previous clock |

## Verification
Two things happen in the same precharge clock: the freshly captured result appears, and the next operand is loaded. The bench checks the new result and the all-rails-fall count in that clock while it applies the next operand at the same moment. It also overlaps capture with operand changes. In every evaluation clock it drives unrelated operand values and then confirms that the result captured at the end of that clock still comes from the operands loaded before it. It also confirms that the previous result stayed visible during that clock. All 512 operand combinations are swept, followed by seeded random operations, and the transition counts are compared against W+1 each time.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    typedef enum logic {
        PH_PRE  = 1'b0,
        PH_EVAL = 1'b1
    } phase_e;

    function automatic rail_t dr_and(rail_t x, rail_t y);
        rail_t r;
        r.t = x.t & y.t;
        r.f = x.f | y.f;
        return r;
    endfunction

    function automatic rail_t dr_or(rail_t x, rail_t y);
        rail_t r;
        r.t = x.t | y.t;
        r.f = x.f & y.f;
        return r;
    endfunction

    // both rails are monotonic sum-of-products terms
    function automatic rail_t dr_xor(rail_t x, rail_t y);
        rail_t r;
        r.t = (x.t & y.f) | (x.f & y.t);
        r.f = (x.t & y.t) | (x.f & y.f);
        return r;
    endfunction

endpackage

// File: rtl/dr_encoder.sv
module dr_encoder
    import dr_pkg::*;
#(
    parameter int W = 9
) (
    input  logic [W-1:0]  val,
    input  logic          pre,
    output rail_t [W-1:0] dr
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dr[i].t =  val[i] & ~pre;
        assign dr[i].f = ~val[i] & ~pre;
    end
endmodule

// File: rtl/dr_adder_net.sv
module dr_adder_net
    import dr_pkg::*;
#(
    parameter int W = 4
) (
    input  rail_t [W-1:0] a,
    input  rail_t [W-1:0] b,
    input  rail_t         cin,
    output rail_t [W:0]   res
);
    rail_t [W:0]   cy;
    rail_t [W-1:0] sm;
    rail_t [W-1:0] pr;

    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_slice
        assign pr[i]   = dr_xor(a[i], b[i]);
        assign sm[i]   = dr_xor(pr[i], cy[i]);
        assign cy[i+1] = dr_or(dr_and(a[i], b[i]), dr_and(pr[i], cy[i]));
    end

    assign res = {cy[W], sm};
endmodule

// File: rtl/dr_capture.sv
module dr_capture
    import dr_pkg::*;
#(
    parameter int N = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  rail_t [N-1:0] d,
    output logic  [N-1:0] q
);
    rail_t [N-1:0] cap;
    logic  [N-1:0] cap_t;
    logic  [N-1:0] cap_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (load) begin
            cap <= d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_dec
        assign cap_t[i] = cap[i].t;
        assign cap_f[i] = cap[i].f;
    end

    assign q = cap_t;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R5
    AST_CAPTURED_VALID: assert property (@(posedge clk) disable iff (rst)
        load |=> &(cap_t ^ cap_f)); // R7
endmodule

// File: rtl/dr_monitor.sv
module dr_monitor
    import dr_pkg::*;
#(
    parameter int N  = 5,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eval,
    input  rail_t [N-1:0] d,
    output logic          err,
    output logic [CW-1:0] rise,
    output logic [CW-1:0] fall
);
    logic [N-1:0]   tv;
    logic [N-1:0]   fv;
    logic [2*N-1:0] cur;
    logic [2*N-1:0] prev;
    logic           viol;

    for (genvar i = 0; i < N; i++) begin : g_split
        assign tv[i] = d[i].t;
        assign fv[i] = d[i].f;
    end

    assign cur  = {tv, fv};
    assign viol = eval ? ((|(tv & fv)) | (|(~tv & ~fv))) : (|cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            err  <= 1'b0;
            prev <= '0;
        end else begin
            err  <= viol;
            prev <= cur;
        end
    end

    assign rise = CW'($countones(cur & ~prev));
    assign fall = CW'($countones(prev & ~cur));

    AST_EVAL_ONE_RAIL: assert property (@(posedge clk) disable iff (rst)
        eval |-> &(tv ^ fv)); // R7
    AST_PRE_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
        !eval |-> (cur == '0)); // R6
    AST_EVAL_RISE_N: assert property (@(posedge clk) disable iff (rst)
        eval |-> (rise == CW'(N) && fall == '0)); // R7
    AST_NO_CODE_ERR: assert property (@(posedge clk) disable iff (rst)
        !err); // R8
endmodule

// File: rtl/dr_wave_adder.sv
module dr_wave_adder
    import dr_pkg::*;
#(
    parameter  int W  = 4,
    localparam int N  = W + 1,
    localparam int CW = $clog2(2 * N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic          c_in,
    output logic          eval_phase,
    output logic [W-1:0]  sum_out,
    output logic          carry_out,
    output logic          code_err,
    output logic [CW-1:0] rise_cnt,
    output logic [CW-1:0] fall_cnt
);
    localparam int IW = 2 * W + 1;

    phase_e         ph;
    logic [IW-1:0]  opnd_q;
    rail_t [IW-1:0] opnd_dr;
    rail_t [N-1:0]  res_dr;
    logic  [N-1:0]  res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_PRE;
            opnd_q <= '0;
        end else begin
            ph <= (ph == PH_PRE) ? PH_EVAL : PH_PRE;
            if (ph == PH_PRE) begin
                opnd_q <= {c_in, b_in, a_in};
            end
        end
    end

    dr_encoder #(.W(IW)) u_enc (
        .val (opnd_q),
        .pre (ph == PH_PRE),
        .dr  (opnd_dr)
    );

    dr_adder_net #(.W(W)) u_net (
        .a   (opnd_dr[W-1:0]),
        .b   (opnd_dr[2*W-1:W]),
        .cin (opnd_dr[2*W]),
        .res (res_dr)
    );

    dr_capture #(.N(N)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .load (ph == PH_EVAL),
        .d    (res_dr),
        .q    (res_q)
    );

    dr_monitor #(.N(N), .CW(CW)) u_mon (
        .clk  (clk),
        .rst  (rst),
        .eval (ph == PH_EVAL),
        .d    (res_dr),
        .err  (code_err),
        .rise (rise_cnt),
        .fall (fall_cnt)
    );

    assign eval_phase = (ph == PH_EVAL);
    assign sum_out    = res_q[W-1:0];
    assign carry_out  = res_q[W];

    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ph != $past(ph))); // R2
    AST_OPND_HELD_IN_EVAL: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EVAL) |=> $stable(opnd_q)); // R3
endmodule

// File: tb/dr_wave_adder_test.sv
module dr_wave_adder_test;
    localparam int W  = 4;
    localparam int N  = W + 1;
    localparam int CW = $clog2(2 * N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  a_in = '0;
    logic [W-1:0]  b_in = '0;
    logic          c_in = 1'b0;
    logic          eval_phase;
    logic [W-1:0]  sum_out;
    logic          carry_out;
    logic          code_err;
    logic [CW-1:0] rise_cnt;
    logic [CW-1:0] fall_cnt;

    int checks   = 0;
    int failures = 0;
    int prev_res = 0;

    always #5ns clk = ~clk;

    dr_wave_adder #(.W(W)) uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .eval_phase(eval_phase), .sum_out(sum_out), .carry_out(carry_out),
        .code_err(code_err), .rise_cnt(rise_cnt), .fall_cnt(fall_cnt)
    );

    function automatic int ref_add(int a, int b, int c);
        return (a + b + c) & ((1 << N) - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts at a negedge inside a precharge clock
    task automatic do_op(input int a, input int b, input int c);
        int exp_res;
        exp_res = ref_add(a, b, c);
        a_in = W'(a);
        b_in = W'(b);
        c_in = c[0];
        @(negedge clk);
        // evaluation clock
        check(eval_phase == 1'b1, "R2 eval phase", int'(eval_phase), 1);
        check(rise_cnt == CW'(N), "R7 rise in eval", int'(rise_cnt), N);
        check(fall_cnt == '0, "R7 fall in eval", int'(fall_cnt), 0);
        check(int'({carry_out, sum_out}) == prev_res, "R5 hold in eval",
              int'({carry_out, sum_out}), prev_res);
        check(code_err == 1'b0, "R8 err after pre", int'(code_err), 0);
        // R3: operands changed during evaluation must not matter
        a_in = W'($urandom);
        b_in = W'($urandom);
        c_in = 1'($urandom);
        @(negedge clk);
        // precharge clock
        check(eval_phase == 1'b0, "R2 pre phase", int'(eval_phase), 0);
        check(int'({carry_out, sum_out}) == exp_res, "R4/R3 result",
              int'({carry_out, sum_out}), exp_res);
        check(rise_cnt == '0, "R6 rise in pre", int'(rise_cnt), 0);
        check(fall_cnt == CW'(N), "R6 fall in pre", int'(fall_cnt), N);
        check(code_err == 1'b0, "R8 err after eval", int'(code_err), 0);
        prev_res = exp_res;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(eval_phase == 1'b0 && sum_out == '0 && carry_out == 1'b0 && code_err == 1'b0,
              "R1 outputs in reset", int'({eval_phase, carry_out, sum_out, code_err}), 0);
        rst = 1'b0;
        // first clock after reset: precharge, nothing moved yet
        check(eval_phase == 1'b0, "R1 phase after reset", int'(eval_phase), 0);
        check(rise_cnt == '0 && fall_cnt == '0, "R1 counts after reset",
              int'({rise_cnt, fall_cnt}), 0);
        check(int'({carry_out, sum_out}) == 0, "R1 result after reset",
              int'({carry_out, sum_out}), 0);
        // directed corners
        do_op(0, 0, 0);
        do_op((1 << W) - 1, (1 << W) - 1, 1);
        do_op((1 << W) - 1, 0, 1);
        do_op(0, 0, 0);
        // exhaustive sweep
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                for (int c = 0; c < 2; c++) begin
                    do_op(a, b, c);
                end
            end
        end
        // seeded random
        for (int k = 0; k < 200; k++) begin
            do_op(int'($urandom) & ((1 << W) - 1), int'($urandom) & ((1 << W) - 1),
                  int'($urandom) & 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1ms;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule